// File: doc/BRIEF.md
# Memory-mapped SPI EEPROM bridge

This block places an external SPI serial EEPROM in a processor's parallel address space. The CPU issues an ordinary read or write with a 16-bit address. The block then drives every serial frame that the EEPROM needs. It holds the CPU off until the whole sequence is over, and then pulses `cpu_ready` for one system clock.

A memory read sends one frame: read opcode, two address bytes, then one byte clocked in. A memory write first sends a one-byte write-enable frame, then the write frame carrying address and data. After that it sends read-status frames until the device reports that its internal write has finished. While `cfg_stat` is set at the start of an access, the access targets the EEPROM status register instead of the array. The serial clock rate, clock polarity and phase, and the chip-select lead and lag times all come from configuration inputs. These inputs must stay stable during an access.

Top module: `spi_eeprom_bridge`

## Requirements
- R1: With `cfg_stat`=0, a CPU read sends one frame of four bytes: 0x03, address[15:8], address[7:0], dummy. Every byte goes MSB first. The byte shifted in during the fourth byte appears on `cpu_rdata` when `cpu_ready` is high.
- R2: With `cfg_stat`=0, a CPU write sends a one-byte frame 0x06 first. A separate four-byte frame follows: 0x02, address[15:8], address[7:0], write data.
- R3: After the write frame of any write access, the block sends two-byte frames of 0x05 and a dummy byte. It repeats them while bit 0 of the returned status byte is 1. It stops after the first frame in which that bit is 0, and only then raises `cpu_ready`.
- R4: With `cfg_stat`=1, a read sends one frame of 0x05 and a dummy byte, and returns the shifted-in byte on `cpu_rdata`. A write sends 0x06, then the frame 0x01 and data, then the polling of R3.
- R5: `cpu_ready` is high for exactly one system clock per access. A strobe still held after that clock starts no new frame until `cpu_sel` and both strobes have been released.
- R6: Inside a frame, each serial clock half period lasts `cfg_div`+1 system clocks, including across byte boundaries.
- R7: Outside a frame, `spi_sck` rests at `cfg_cpol`. With `cfg_cpha`=0, data is sampled on the edge leaving the rest level. With `cfg_cpha`=1, data is sampled on the edge returning to it. The block shifts out on the opposite edge.
- R8: From `spi_cs_n` falling to the first `spi_sck` edge takes (`cfg_setup`+2)(`cfg_div`+1) system clocks. From the last edge to `spi_cs_n` rising takes (`cfg_hold`+1)(`cfg_div`+1) system clocks.
- R9: Between two frames of one access, `spi_cs_n` stays high for at least 2(`cfg_div`+1) system clocks.
- R10: During and right after reset, `spi_cs_n` is 1, `cpu_ready` is 0 and `spi_sck` equals `cfg_cpol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cpu_sel | input | 1 | CPU select of the bridge |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_addr | input | 16 | CPU byte address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data, valid while cpu_ready is high |
| cpu_ready | output | 1 | One-clock access completion |
| cfg_div | input | DIV_W | Prescaler: half period is cfg_div+1 clocks |
| cfg_cpol | input | 1 | Serial clock rest level |
| cfg_cpha | input | 1 | Serial clock phase |
| cfg_setup | input | CNT_W | Chip-select lead time in half periods |
| cfg_hold | input | CNT_W | Chip-select lag time in half periods |
| cfg_stat | input | 1 | Target the status register |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the EEPROM |
| spi_miso | input | 1 | Serial data from the EEPROM |
| spi_cs_n | output | 1 | EEPROM chip select, active low |

## Verification
A behavioural EEPROM in the bench answers the frames. Its write-in-progress flag stays set for two status polls after each write. Accesses run through array writes and read-backs, status-register writes and reads, and unwritten and extreme addresses. These are spread over all four clock modes and several prescaler, lead and lag settings. Wrong read data separates a phase or bit-order error from a sequencing error, because a wrong opcode, a missing write-enable frame or a short poll loop shows up in the logged frame sequence. Per-edge timing separates prescaler and lead/lag faults. A held strobe after completion shows whether the access can be re-entered by mistake.

// File: rtl/spi_eeprom_bridge.sv
module spi_eeprom_bridge #(
  parameter int DIV_W = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_sel,
  input  logic             cpu_rd,
  input  logic             cpu_wr,
  input  logic [15:0]      cpu_addr,
  input  logic [7:0]       cpu_wdata,
  output logic [7:0]       cpu_rdata,
  output logic             cpu_ready,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_cpol,
  input  logic             cfg_cpha,
  input  logic [CNT_W-1:0] cfg_setup,
  input  logic [CNT_W-1:0] cfg_hold,
  input  logic             cfg_stat,
  output logic             spi_sck,
  output logic             spi_mosi,
  input  logic             spi_miso,
  output logic             spi_cs_n
);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_XFER, S_HOLD, S_GAP, S_DONE, S_WAIT} st_t;
  typedef enum logic [2:0] {K_WREN, K_READ, K_WRITE, K_RDSR, K_WRSR} kind_t;

  st_t              st;
  kind_t            kind;
  logic [DIV_W-1:0] pre;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       idx;
  logic [3:0]       h;
  logic [7:0]       tx, rx, res;
  logic [15:0]      a_q;
  logic [7:0]       d_q;
  logic             wr_q, stat_q, sck_q, mosi_q;
  logic [7:0]       lb;
  logic [1:0]       last;
  logic             req, run, tick;

  function automatic logic [7:0] pick(kind_t k, logic [1:0] i, logic [15:0] a, logic [7:0] d);
    case (k)
      K_WREN:         pick = 8'h06;
      K_READ, K_WRITE:
        case (i)
          2'd0:    pick = (k == K_READ) ? 8'h03 : 8'h02;
          2'd1:    pick = a[15:8];
          2'd2:    pick = a[7:0];
          default: pick = (k == K_READ) ? 8'h00 : d;
        endcase
      K_RDSR:         pick = (i == 2'd0) ? 8'h05 : 8'h00;
      K_WRSR:         pick = (i == 2'd0) ? 8'h01 : d;
      default:        pick = 8'h00;
    endcase
  endfunction

  assign req  = cpu_sel && (cpu_rd || cpu_wr);
  assign run  = (st == S_SETUP) || (st == S_XFER) || (st == S_HOLD) || (st == S_GAP);
  assign tick = run && (pre == cfg_div);
  assign lb   = pick(kind, (st == S_XFER) ? idx + 2'd1 : 2'd0, a_q, d_q);
  assign last = (kind == K_WREN) ? 2'd0 : ((kind == K_READ || kind == K_WRITE) ? 2'd3 : 2'd1);

  assign spi_cs_n  = !((st == S_SETUP) || (st == S_XFER) || (st == S_HOLD));
  assign spi_sck   = (st == S_XFER) ? sck_q : cfg_cpol;
  assign spi_mosi  = mosi_q;
  assign cpu_ready = (st == S_DONE);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     pre <= '0;
    else if (!run)  pre <= '0;
    else if (tick)  pre <= '0;
    else            pre <= pre + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; kind <= K_READ; cnt <= '0; idx <= '0; h <= '0;
      tx <= '0; rx <= '0; res <= '0; cpu_rdata <= '0;
      a_q <= '0; d_q <= '0; wr_q <= 1'b0; stat_q <= 1'b0;
      sck_q <= 1'b0; mosi_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE:
          if (req) begin
            a_q <= cpu_addr; d_q <= cpu_wdata; wr_q <= cpu_wr; stat_q <= cfg_stat;
            kind <= cpu_wr ? K_WREN : (cfg_stat ? K_RDSR : K_READ);
            cnt <= '0;
            st <= S_SETUP;
          end
        S_SETUP:
          if (tick) begin
            if (cnt == cfg_setup) begin
              st <= S_XFER; idx <= '0; h <= '0; sck_q <= cfg_cpol;
              if (cfg_cpha) tx <= lb;
              else begin mosi_q <= lb[7]; tx <= {lb[6:0], 1'b0}; end
            end else cnt <= cnt + 1'b1;
          end
        S_XFER:
          if (tick) begin
            sck_q <= ~sck_q;
            h <= h + 4'd1;
            if (h[0] == cfg_cpha) rx <= {rx[6:0], spi_miso};
            else if (h != 4'd15) begin mosi_q <= tx[7]; tx <= {tx[6:0], 1'b0}; end
            if (h == 4'd15) begin
              res <= cfg_cpha ? {rx[6:0], spi_miso} : rx;
              if (idx == last) begin
                st <= S_HOLD; cnt <= '0;
              end else begin
                idx <= idx + 2'd1;
                if (cfg_cpha) tx <= lb;
                else begin mosi_q <= lb[7]; tx <= {lb[6:0], 1'b0}; end
              end
            end
          end
        S_HOLD:
          if (tick) begin
            if (cnt == cfg_hold) begin st <= S_GAP; cnt <= '0; end
            else cnt <= cnt + 1'b1;
          end
        S_GAP:
          if (tick) begin
            if (cnt == CNT_W'(1)) begin
              cnt <= '0;
              case (kind)
                K_WREN:          begin kind <= stat_q ? K_WRSR : K_WRITE; st <= S_SETUP; end
                K_WRITE, K_WRSR: begin kind <= K_RDSR; st <= S_SETUP; end
                K_RDSR:
                  if (wr_q && res[0]) st <= S_SETUP;
                  else begin
                    st <= S_DONE;
                    if (!wr_q) cpu_rdata <= res;
                  end
                default:         begin cpu_rdata <= res; st <= S_DONE; end
              endcase
            end else cnt <= cnt + 1'b1;
          end
        S_DONE: st <= S_WAIT;
        S_WAIT: if (!req) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R5
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);

  // R5
  ready_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> req);

  // R1
  ready_idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> spi_cs_n);

  // R7
  cs_fall_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> (spi_sck == cfg_cpol));

  // R6
  sck_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(spi_sck) && $stable(cfg_cpol)) |-> !spi_cs_n);

  // R9
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |=> spi_cs_n);

endmodule

// File: tb/spi_eeprom_bridge_tb.sv
module spi_eeprom_bridge_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_sel = 0, cpu_rd = 0, cpu_wr = 0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic        cpu_ready;
  logic [7:0]  cfg_div = '0;
  logic        cfg_cpol = 1'b1, cfg_cpha = 1'b0, cfg_stat = 1'b0;
  logic [3:0]  cfg_setup = '0, cfg_hold = '0;
  logic        spi_sck, spi_mosi, spi_cs_n;
  logic        spi_miso = 1'b0;

  always #4 clk = ~clk;

  spi_eeprom_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .cfg_div(cfg_div), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_setup(cfg_setup),
    .cfg_hold(cfg_hold), .cfg_stat(cfg_stat), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  int tests = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // EEPROM model and frame/timing monitor, evaluated away from the active edge
  logic [7:0] mem [int];
  logic [7:0] sr = 8'h00;
  logic       wel = 1'b0;
  int         busy = 0;
  int         bits = 0, nb = 0;
  logic [7:0] rxb = '0;
  logic [7:0] fb [4];
  logic [7:0] ops [8];
  logic [7:0] fa1 [8], fa2 [8];
  int         fnb [8];
  int         fr = 0;
  logic       prev_cs = 1'b1, prev_sck = 1'b1;
  int         cyc = 0, t_fall = 0, t_edge = 0, t_rise = 0;
  bit         first_edge = 0, have_rise = 0;
  int         exp_half = 1, exp_setup = 2, exp_hold = 1;
  int         setup_bad = 0, hold_bad = 0, half_bad = 0, gap_min = 0, cs_falls = 0;

  function automatic logic outbit();
    logic [7:0] ob;
    int bi, pos;
    bi = bits / 8; pos = bits % 8;
    ob = 8'h00;
    if (bi == 3 && fb[0] == 8'h03) begin
      if (mem.exists({16'h0, fb[1], fb[2]})) ob = mem[{16'h0, fb[1], fb[2]}];
    end else if (bi == 1 && fb[0] == 8'h05)
      ob = {sr[7:2], wel, busy != 0};
    return ob[7-pos];
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (prev_cs && !spi_cs_n) begin
      bits = 0; nb = 0; cs_falls++;
      for (int k = 0; k < 4; k++) fb[k] = 8'h00;
      spi_miso = outbit();
      t_fall = cyc; first_edge = 1;
      if (have_rise && (gap_min == 0 || cyc - t_rise < gap_min)) gap_min = cyc - t_rise;
    end else if (!spi_cs_n && spi_sck != prev_sck) begin
      if ((spi_sck != cfg_cpol) == !cfg_cpha) begin
        rxb = {rxb[6:0], spi_mosi};
        bits++;
        if (bits % 8 == 0) begin
          if (nb < 4) fb[nb] = rxb;
          nb++;
        end
      end else spi_miso = outbit();
      if (first_edge) begin
        if (cyc - t_fall != exp_setup) setup_bad++;
        first_edge = 0;
      end else if (cyc - t_edge != exp_half) half_bad++;
      t_edge = cyc;
    end else if (!prev_cs && spi_cs_n) begin
      if (cyc - t_edge != exp_hold) hold_bad++;
      t_rise = cyc; have_rise = 1;
      if (fr < 8) begin
        ops[fr] = fb[0]; fa1[fr] = fb[1]; fa2[fr] = fb[2]; fnb[fr] = nb;
      end
      fr++;
      case (fb[0])
        8'h06: wel = 1'b1;
        8'h02: if (wel && nb == 4) begin mem[{16'h0, fb[1], fb[2]}] = fb[3]; busy = 2; wel = 1'b0; end
        8'h01: if (wel && nb == 2) begin sr = {fb[1][7:2], 2'b00}; busy = 2; wel = 1'b0; end
        8'h05: if (busy > 0) busy--;
        default: ;
      endcase
    end
    prev_cs = spi_cs_n; prev_sck = spi_sck;
  end

  int wd = 0;
  always @(negedge clk) begin
    wd++;
    if (wd > 150000) begin
      fails++; tests++;
      $display("FAIL watchdog: got 0x%0h expected 0x0", wd);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // wr stat addr data div cpol cpha setup hold expected
  localparam int NV = 11;
  localparam logic [45:0] VEC [NV] = '{
    {1'b1, 1'b0, 16'h1234, 8'hA5, 4'd0,  1'b0, 1'b0, 3'd0, 3'd0, 8'h00},
    {1'b0, 1'b0, 16'h1234, 8'h00, 4'd1,  1'b0, 1'b0, 3'd1, 3'd0, 8'hA5},
    {1'b1, 1'b0, 16'h00FF, 8'h3C, 4'd2,  1'b1, 1'b1, 3'd2, 3'd1, 8'h00},
    {1'b0, 1'b0, 16'h00FF, 8'h00, 4'd0,  1'b0, 1'b1, 3'd0, 3'd2, 8'h3C},
    {1'b0, 1'b0, 16'h1234, 8'h00, 4'd3,  1'b1, 1'b0, 3'd1, 3'd1, 8'hA5},
    {1'b1, 1'b1, 16'h0000, 8'h8F, 4'd1,  1'b0, 1'b0, 3'd0, 3'd0, 8'h00},
    {1'b0, 1'b1, 16'h0000, 8'h00, 4'd0,  1'b1, 1'b1, 3'd0, 3'd0, 8'h8C},
    {1'b1, 1'b0, 16'hFFFF, 8'h01, 4'd0,  1'b1, 1'b0, 3'd3, 3'd0, 8'h00},
    {1'b0, 1'b0, 16'hFFFF, 8'h00, 4'd2,  1'b0, 1'b1, 3'd0, 3'd3, 8'h01},
    {1'b0, 1'b0, 16'h0000, 8'h00, 4'd0,  1'b0, 1'b0, 3'd0, 3'd0, 8'h00},
    {1'b0, 1'b0, 16'h1234, 8'h00, 4'd15, 1'b0, 1'b1, 3'd7, 3'd7, 8'hA5}
  };

  task automatic run_access(input logic w, input logic st, input logic [15:0] a,
                            input logic [7:0] d, input logic [3:0] dv, input logic po,
                            input logic ph, input logic [2:0] su, input logic [2:0] ho,
                            input logic [7:0] ex, input bit hold_strobe);
    logic [39:0] got, expo;
    logic [7:0]  rd;
    int          rcnt, nf;
    @(negedge clk);
    cfg_div = {4'd0, dv}; cfg_cpol = po; cfg_cpha = ph; cfg_stat = st;
    cfg_setup = {1'b0, su}; cfg_hold = {1'b0, ho};
    exp_half = dv + 1; exp_setup = (su + 2) * (dv + 1); exp_hold = (ho + 1) * (dv + 1);
    setup_bad = 0; hold_bad = 0; half_bad = 0; gap_min = 0; have_rise = 0; fr = 0;
    @(negedge clk);
    cpu_sel = 1; cpu_rd = !w; cpu_wr = w; cpu_addr = a; cpu_wdata = d;
    while (!cpu_ready) @(negedge clk);
    rd = cpu_rdata; rcnt = 0;
    while (cpu_ready) begin rcnt++; @(negedge clk); end
    chk(rcnt == 1, "R5 ready width", rcnt, 1);
    if (hold_strobe) begin
      cs_falls = 0;
      repeat (60) @(negedge clk);
      chk(cs_falls == 0 && spi_cs_n && !cpu_ready, "R5 held strobe restarts", cs_falls, 0);
    end
    cpu_sel = 0; cpu_rd = 0; cpu_wr = 0;
    repeat (3) @(negedge clk);
    nf = fr;
    chk(spi_sck == po, "R7 rest level", spi_sck, po);
    chk(setup_bad == 0, "R8 setup", setup_bad, 0);
    chk(hold_bad == 0, "R8 hold", hold_bad, 0);
    chk(half_bad == 0, "R6 half period", half_bad, 0);
    if (!w) begin
      chk(nf == 1, st ? "R4 frame count" : "R1 frame count", nf, 1);
      chk(rd == ex, st ? "R4 status read data" : "R1 read data", rd, ex);
      if (st) chk(ops[0] == 8'h05 && fnb[0] == 2, "R4 status read frame", ops[0], 8'h05);
      else chk(ops[0] == 8'h03 && fnb[0] == 4 && fa1[0] == a[15:8] && fa2[0] == a[7:0],
               "R1 read frame", {ops[0], fa1[0], fa2[0]}, {8'h03, a});
    end else begin
      got  = {ops[0], ops[1], ops[2], ops[3], ops[4]};
      expo = {8'h06, st ? 8'h01 : 8'h02, 8'h05, 8'h05, 8'h05};
      chk(nf == 5, "R3 poll frame count", nf, 5);
      chk(got == expo, st ? "R4 write sequence" : "R2 write sequence", got, expo);
      chk(fnb[0] == 1 && fnb[1] == (st ? 2 : 4), "R2 frame lengths", fnb[1], st ? 2 : 4);
      if (!st) chk(fa1[1] == a[15:8] && fa2[1] == a[7:0], "R2 write address", {fa1[1], fa2[1]}, a);
      chk(fnb[2] == 2 && fnb[4] == 2, "R3 poll frame length", fnb[4], 2);
      chk(gap_min >= 2 * (dv + 1), "R9 frame gap", gap_min, 2 * (dv + 1));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(spi_cs_n == 1 && cpu_ready == 0 && spi_sck == 1, "R10 reset outputs",
        {spi_cs_n, cpu_ready, spi_sck}, 3'b101);
    cfg_cpol = 1'b0;
    @(negedge clk);
    chk(spi_sck == 0, "R10 rest follows polarity", spi_sck, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(spi_cs_n == 1 && cpu_ready == 0, "R10 after reset", {spi_cs_n, cpu_ready}, 2'b10);
    for (int i = 0; i < NV; i++) begin
      logic [45:0] v;
      v = VEC[i];
      run_access(v[45], v[44], v[43:28], v[27:20], v[19:16], v[15], v[14],
                 v[13:11], v[10:8], v[7:0], 1'b0);
    end
    // R5: strobe held after completion must not start another access
    run_access(1'b0, 1'b0, 16'h00FF, 8'h00, 4'd0, 1'b0, 1'b0, 3'd0, 3'd0, 8'h3C, 1'b1);
    // R3: write to a fresh location, read it back under a different mode
    run_access(1'b1, 1'b0, 16'h8001, 8'h5A, 4'd1, 1'b1, 1'b1, 3'd0, 3'd0, 8'h00, 1'b1);
    run_access(1'b0, 1'b0, 16'h8001, 8'h00, 4'd0, 1'b1, 1'b0, 3'd0, 3'd0, 8'h5A, 1'b0);
    cs_falls = 0;
    repeat (30) @(negedge clk);
    chk(cs_falls == 0 && !cpu_ready, "R5 idle without strobe", cs_falls, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule